// File: doc/BRIEF.md
# CEC Receive Error-Bit Policy

This block sits beside a CEC receiver's bit-timing checker and turns its error detections into actions. Each cycle it sees three one-cycle detect pulses: a rising edge that came too early within a bit, a bit period that ran too long, and a bit period that ended too short. From these pulses, the broadcast flag of the current message, the listen-mode flag and four configuration enables, it decides two things: whether the receiver abandons the current message, and whether the line driver must emit an error bit. It also tells the bit sampler which sample point to use.

The decision logic is combinational. Its result is registered once, so every output follows its cause by one clock. A message start pulse re-arms the block. After an abort, nothing more is reported until the next message starts, so a message produces at most one error-bit request.

Top module: `cec_errpol`

## Requirements
- R1: After reset `err_bit_o` and `rx_halt_o` are 0 and `smp_tick_o` equals `SMP_FIXED`.
- R2: One cycle after any cycle, `smp_tick_o` equals `SMP_ALT` if `cfg_stop_rise_i` was 1 in that cycle, else `SMP_FIXED` (the fixed late point, 1.05 ms).
- R3: With `cfg_stop_rise_i`=0, a rising-error pulse neither sets `rx_halt_o` nor produces `err_bit_o`.
- R4: With `cfg_stop_rise_i`=1, a rising-error pulse sets `rx_halt_o` one cycle later. In a non-broadcast message it produces `err_bit_o` only when `cfg_gen_rise_i`=1.
- R5: In a broadcast message with `cfg_stop_rise_i`=1 and `cfg_gen_rise_i`=0, a rising-error pulse produces `err_bit_o` when `cfg_bc_quiet_i`=0 and no error bit when it is 1. With `cfg_gen_rise_i`=1 the error bit is produced regardless of `cfg_bc_quiet_i`.
- R6: A long-period pulse produces `err_bit_o` and sets `rx_halt_o` exactly when `cfg_gen_long_i`=1. Otherwise it has no effect on either output.
- R7: A short-period pulse produces `err_bit_o` and sets `rx_halt_o`, except when `bcast_i`, `listen_i` and `cfg_bc_quiet_i` are all 1. In that case it has no effect.
- R8: `err_bit_o` is a single-cycle pulse in the cycle after the detect pulse, and `rx_halt_o` is 1 whenever `err_bit_o` is 1.
- R9: While `rx_halt_o` is 1, detect pulses have no effect. A `msg_start_i` pulse clears `rx_halt_o` one cycle later. Detect pulses in the same cycle as `msg_start_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_start_i | input | 1 | Pulse: a start bit was received, a new message begins |
| rise_err_i | input | 1 | Pulse: rising edge too early within a bit |
| long_err_i | input | 1 | Pulse: bit period too long |
| short_err_i | input | 1 | Pulse: bit period too short |
| bcast_i | input | 1 | Current message is broadcast |
| listen_i | input | 1 | Listen mode active |
| cfg_stop_rise_i | input | 1 | Abort on rising error |
| cfg_gen_rise_i | input | 1 | Error bit on rising error (with abort) |
| cfg_gen_long_i | input | 1 | Error bit on long period |
| cfg_bc_quiet_i | input | 1 | Suppress some error bits in broadcast |
| err_bit_o | output | 1 | Pulse: line driver must emit an error bit |
| rx_halt_o | output | 1 | Reception of the current message abandoned |
| smp_tick_o | output | SMP_W | Sample point for the current bit, in sampler ticks |

## Verification
The bench builds the block with `SMP_W`=8, `SMP_FIXED`=105 and `SMP_ALT`=96. Because the two sample points differ, a swapped or stuck sample-point selection shows at the port. The bench walks the full enable space for each error kind, in broadcast and non-broadcast messages and with listen mode on and off. This reaches every suppression corner. It also stacks detect pulses after an abort and on the start pulse itself, which exercises the one-per-message gate.

// File: rtl/cec_errpol_pkg.sv
package cec_errpol_pkg;

  typedef struct packed {
    logic stop_rise;
    logic gen_rise;
    logic gen_long;
    logic bc_quiet;
  } errpol_cfg_t;

  typedef struct packed {
    logic rise;
    logic long_p;
    logic short_p;
  } errpol_evt_t;

  // rising error: needs abort; then its own enable, or broadcast without quiet
  function automatic logic rise_wants_bit(errpol_cfg_t c, logic bc);
    return c.stop_rise & (c.gen_rise | (bc & ~c.bc_quiet));
  endfunction

  // short period: silenced only for quiet broadcast listening
  function automatic logic short_wants_bit(errpol_cfg_t c, logic bc, logic lsn);
    return ~(bc & lsn & c.bc_quiet);
  endfunction

  function automatic logic any_bit(errpol_cfg_t c, errpol_evt_t e,
                                   logic bc, logic lsn);
    return (e.rise & rise_wants_bit(c, bc)) |
           (e.long_p & c.gen_long) |
           (e.short_p & short_wants_bit(c, bc, lsn));
  endfunction

  function automatic logic any_halt(errpol_cfg_t c, errpol_evt_t e, logic bit_req);
    return bit_req | (e.rise & c.stop_rise);
  endfunction

endpackage

// File: rtl/cec_errpol_decide.sv
module cec_errpol_decide
  import cec_errpol_pkg::*;
(
  input  errpol_cfg_t cfg,
  input  errpol_evt_t evt,
  input  logic        bcast,
  input  logic        listen,
  output logic        want_bit,
  output logic        want_halt
);
  always_comb begin
    want_bit  = any_bit(cfg, evt, bcast, listen);
    want_halt = any_halt(cfg, evt, want_bit);
  end
endmodule

// File: rtl/cec_errpol_track.sv
module cec_errpol_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic want_bit,
  input  logic want_halt,
  output logic err_pulse,
  output logic halted
);
  logic live;
  assign live = ~halted & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      halted    <= 1'b0;
    end else begin
      err_pulse <= live & want_bit;
      if (start) halted <= 1'b0;
      else if (live & want_halt) halted <= 1'b1;
    end
  end

  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  p_bit_implies_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> halted);
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!halted && !err_pulse));
  p_halt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> (halted && !err_pulse));
endmodule

// File: rtl/cec_errpol_smp.sv
module cec_errpol_smp #(
  parameter int SMP_W     = 8,
  parameter int SMP_FIXED = 105,
  parameter int SMP_ALT   = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_rise,
  output logic [SMP_W-1:0] smp_tick
);
  localparam logic [SMP_W-1:0] FIXED_V = SMP_W'(SMP_FIXED);
  localparam logic [SMP_W-1:0] ALT_V   = SMP_W'(SMP_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_tick <= FIXED_V;
    else        smp_tick <= stop_rise ? ALT_V : FIXED_V;
  end

  p_fixed_point_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_rise |=> (smp_tick == FIXED_V));
  p_alt_point_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rise |=> (smp_tick == ALT_V));
endmodule

// File: rtl/cec_errpol.sv
module cec_errpol
  import cec_errpol_pkg::*;
#(
  parameter int SMP_W     = 8,
  parameter int SMP_FIXED = 105,
  parameter int SMP_ALT   = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start_i,
  input  logic             rise_err_i,
  input  logic             long_err_i,
  input  logic             short_err_i,
  input  logic             bcast_i,
  input  logic             listen_i,
  input  logic             cfg_stop_rise_i,
  input  logic             cfg_gen_rise_i,
  input  logic             cfg_gen_long_i,
  input  logic             cfg_bc_quiet_i,
  output logic             err_bit_o,
  output logic             rx_halt_o,
  output logic [SMP_W-1:0] smp_tick_o
);
  errpol_cfg_t cfg;
  errpol_evt_t evt;
  logic        want_bit, want_halt;

  assign cfg = '{stop_rise: cfg_stop_rise_i, gen_rise: cfg_gen_rise_i,
                 gen_long: cfg_gen_long_i, bc_quiet: cfg_bc_quiet_i};
  assign evt = '{rise: rise_err_i, long_p: long_err_i, short_p: short_err_i};

  cec_errpol_decide u_decide (
    .cfg(cfg), .evt(evt), .bcast(bcast_i), .listen(listen_i),
    .want_bit(want_bit), .want_halt(want_halt));

  cec_errpol_track u_track (
    .clk(clk), .rst_n(rst_n), .start(msg_start_i),
    .want_bit(want_bit), .want_halt(want_halt),
    .err_pulse(err_bit_o), .halted(rx_halt_o));

  cec_errpol_smp #(.SMP_W(SMP_W), .SMP_FIXED(SMP_FIXED), .SMP_ALT(SMP_ALT)) u_smp (
    .clk(clk), .rst_n(rst_n), .stop_rise(cfg_stop_rise_i), .smp_tick(smp_tick_o));

  // port-level policy checks
  p_rise_no_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_err_i && !cfg_stop_rise_i && !long_err_i && !short_err_i && !rx_halt_o)
      |=> (!rx_halt_o && !err_bit_o));
  p_rise_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_err_i && cfg_stop_rise_i && !msg_start_i) |=> rx_halt_o);
  p_bcast_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_err_i && bcast_i && cfg_bc_quiet_i && !cfg_gen_rise_i &&
     !long_err_i && !short_err_i) |=> !err_bit_o);
  p_long_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (long_err_i && !cfg_gen_long_i && !rise_err_i && !short_err_i && !rx_halt_o)
      |=> !rx_halt_o);
  p_short_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (short_err_i && bcast_i && listen_i && cfg_bc_quiet_i &&
     !rise_err_i && !long_err_i) |=> !err_bit_o);
endmodule

// File: tb/sim_cec_errpol.sv
module sim_cec_errpol;
  localparam int W = 8, FIX = 105, ALT = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rise = 0, lng = 0, sht = 0, bc = 0, lsn = 0;
  logic c_stop = 0, c_grise = 0, c_glong = 0, c_quiet = 0;
  logic err_bit, halt;
  logic [W-1:0] smp;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cec_errpol #(.SMP_W(W), .SMP_FIXED(FIX), .SMP_ALT(ALT)) u0 (
    .clk(clk), .rst_n(rst_n), .msg_start_i(start), .rise_err_i(rise),
    .long_err_i(lng), .short_err_i(sht), .bcast_i(bc), .listen_i(lsn),
    .cfg_stop_rise_i(c_stop), .cfg_gen_rise_i(c_grise),
    .cfg_gen_long_i(c_glong), .cfg_bc_quiet_i(c_quiet),
    .err_bit_o(err_bit), .rx_halt_o(halt), .smp_tick_o(smp));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // new message: pulse start, outputs clear one cycle later
  task automatic new_msg();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  // one-cycle detect pulse; sample the outputs after the next edge
  task automatic fire(input logic r, input logic l, input logic s,
                      output logic eb, output logic hl);
    @(negedge clk); rise = r; lng = l; sht = s;
    @(negedge clk); rise = 0; lng = 0; sht = 0;
    eb = err_bit; hl = halt;
  endtask

  task automatic t_reset();
    chk("R1 err_bit", int'(err_bit), 0);
    chk("R1 halt", int'(halt), 0);
    chk("R1 smp", int'(smp), FIX);
  endtask

  task automatic t_sample();
    @(negedge clk); c_stop = 1;
    @(negedge clk); chk("R2 smp alt", int'(smp), ALT);
    c_stop = 0;
    @(negedge clk); chk("R2 smp fixed", int'(smp), FIX);
  endtask

  task automatic t_rise_nostop();
    logic eb, hl;
    for (int g = 0; g < 2; g++) begin
      c_stop = 0; c_grise = g[0]; bc = g[0];
      new_msg();
      fire(1, 0, 0, eb, hl);
      chk("R3 no err_bit", int'(eb), 0);
      chk("R3 no halt", int'(hl), 0);
    end
  endtask

  task automatic t_rise_stop();
    logic eb, hl;
    bc = 0; c_stop = 1;
    for (int g = 0; g < 2; g++) begin
      c_grise = g[0];
      new_msg();
      fire(1, 0, 0, eb, hl);
      chk("R4 halt", int'(hl), 1);
      chk("R4 err_bit", int'(eb), g);
    end
  endtask

  task automatic t_bcast_rise();
    logic eb, hl;
    bc = 1; c_stop = 1;
    for (int k = 0; k < 4; k++) begin
      c_grise = k[1]; c_quiet = k[0];
      new_msg();
      fire(1, 0, 0, eb, hl);
      chk("R5 err_bit", int'(eb), (k[1] || !k[0]) ? 1 : 0);
      chk("R5 halt", int'(hl), 1);
    end
    c_quiet = 0; c_grise = 0; c_stop = 0; bc = 0;
  endtask

  task automatic t_long();
    logic eb, hl;
    for (int g = 0; g < 2; g++) begin
      c_glong = g[0];
      new_msg();
      fire(0, 1, 0, eb, hl);
      chk("R6 err_bit", int'(eb), g);
      chk("R6 halt", int'(hl), g);
    end
    c_glong = 0;
  endtask

  task automatic t_short();
    logic eb, hl;
    int exp;
    for (int k = 0; k < 8; k++) begin
      bc = k[2]; lsn = k[1]; c_quiet = k[0];
      exp = (k == 7) ? 0 : 1;
      new_msg();
      fire(0, 0, 1, eb, hl);
      chk("R7 err_bit", int'(eb), exp);
      chk("R7 halt", int'(hl), exp);
    end
    bc = 0; lsn = 0; c_quiet = 0;
  endtask

  task automatic t_pulse_once();
    logic eb, hl;
    c_glong = 1;
    new_msg();
    fire(0, 1, 0, eb, hl);
    chk("R8 first err_bit", int'(eb), 1);
    @(negedge clk);
    chk("R8 pulse width", int'(err_bit), 0);
    chk("R8 halt held", int'(halt), 1);
    fire(0, 0, 1, eb, hl);
    chk("R9 no second err_bit", int'(eb), 0);
    chk("R9 halt kept", int'(hl), 1);
    new_msg();
    chk("R9 start clears halt", int'(halt), 0);
    // detect pulses on the start cycle are ignored
    @(negedge clk); start = 1; sht = 1; lng = 1;
    @(negedge clk); start = 0; sht = 0; lng = 0;
    chk("R9 start-cycle err_bit", int'(err_bit), 0);
    chk("R9 start-cycle halt", int'(halt), 0);
    c_glong = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_sample();
    t_rise_nostop();
    t_rise_stop();
    t_bcast_rise();
    t_long();
    t_short();
    t_pulse_once();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule